// File: doc/BRIEF.md
# Fragment-Aware Translation Lookaside Buffer

This block is a small fully associative translation cache. Each entry can map a page larger than 4 KB. The size of that page comes from a three-bit fragment code f carried in the page table entry. One entry with code f covers 2^f consecutive 4 KB virtual pages. Those pages map onto the same number of physically contiguous pages, and all of them share one set of permission flags. Holding a whole fragment in one entry lets the cache hold far more address space than a cache with one entry per 4 KB page.

A lookup presents a virtual address and gets back a registered hit bit, a physical address and flags one cycle later. After a miss, a page walker outside this block fetches the page table entry and installs it through the fill port, together with the virtual page number that missed. Storage is split into two partitions by page size. Plain 4 KB pages go into a small partition and fragments into a larger one, so small pages cannot evict the large mappings. A flush input invalidates every entry at once.

Top module: `frag_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_hit` is 0, and any lookup misses until a fill is made.
- R2: `fill_pte` is decoded as follows. Bit 0 is the valid bit, bits [6:1] are the flags, bits [9:7] are the fragment code f, and bits [12+PPN_W-1:12] are the physical page number. A fill with bit 0 clear leaves the cache unchanged.
- R3: A lookup hits an entry when the lookup page number and the entry's page number are equal after both have their low f bits cleared. One entry therefore serves 2^f pages, and a page outside that aligned range misses.
- R4: On a hit, the physical page is the entry's page number, with its low f bits cleared, OR'd with the low f bits of the lookup page number. `rsp_pa` is that page followed by the 12 offset bits of `lk_va`, and `rsp_flags` holds the entry's flags.
- R5: The response is registered. `rsp_hit`, `rsp_pa` and `rsp_flags` reflect a request one cycle after it. In a cycle with no request or a miss, `rsp_hit`, `rsp_pa` and `rsp_flags` are 0.
- R6: Fills with f = 0 go to the SMALL_N-entry partition and fills with f > 0 go to the LARGE_N-entry partition. Each partition replaces its own slots round-robin, starting at its first slot after reset, and a fill to one partition never disturbs the other.
- R7: A flush invalidates all entries in one cycle. A lookup in the flush cycle misses, and a fill in the flush cycle is dropped. Flush does not move the replacement pointers.
- R8: A lookup in the same cycle as a fill sees the contents from before that fill. The new entry is visible from the next cycle.
- R9: When several entries match, the small partition wins over the large one, and within a partition the lowest slot wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VPN_W+12 | Lookup virtual address |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Virtual page number that missed |
| fill_pte | input | PPN_W+12 | Page table entry to install |
| rsp_hit | output | 1 | Registered hit |
| rsp_pa | output | PPN_W+12 | Registered physical address |
| rsp_flags | output | 6 | Registered permission flags |

## Verification
The bench looks up pages at both ends of a fragment and just past them. A design that masks the wrong number of bits would then hit outside the range, or return a base page instead of the page offset inside the fragment. It also overflows the small partition and checks which entry was lost. A shared or badly wrapped pointer would evict a large mapping or the wrong small slot. Collisions of flush with lookup and fill, fills that land in the cycle of a lookup, and overlapping entries expose stale hits, early visibility of a new entry and the wrong match priority. A long random phase with a narrow address space mixes all of these cases.

// File: rtl/frag_tlb.sv
module frag_tlb #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 28,
  parameter int SMALL_N = 4,
  parameter int LARGE_N = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lk_req,
  input  logic [VPN_W+11:0]  lk_va,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W+11:0]  fill_pte,
  output logic               rsp_hit,
  output logic [PPN_W+11:0]  rsp_pa,
  output logic [5:0]         rsp_flags
);
  localparam int ENT   = SMALL_N + LARGE_N;
  localparam int IDX_W = $clog2(ENT);
  localparam int SP_W  = SMALL_N > 1 ? $clog2(SMALL_N) : 1;
  localparam int LP_W  = LARGE_N > 1 ? $clog2(LARGE_N) : 1;

  logic [VPN_W-1:0] e_vpn [ENT];
  logic [PPN_W-1:0] e_ppn [ENT];
  logic [5:0]       e_flg [ENT];
  logic [2:0]       e_frag[ENT];
  logic [ENT-1:0]   valid;
  logic [SP_W-1:0]  sp;
  logic [LP_W-1:0]  lp;

  wire [VPN_W-1:0] lk_vpn    = lk_va[VPN_W+11:12];
  wire [2:0]       fill_frag = fill_pte[9:7];
  wire             fill_ok   = fill_en & fill_pte[0] & ~flush;
  wire             to_small  = (fill_frag == 3'd0);
  wire [IDX_W-1:0] widx      = to_small ? IDX_W'(sp) : IDX_W'(SMALL_N) + IDX_W'(lp);
  wire [VPN_W-1:0] fill_mask = {VPN_W{1'b1}} << fill_frag;

  logic             hit_c;
  logic [IDX_W-1:0] sel;
  always_comb begin
    hit_c = 1'b0;
    sel   = '0;
    for (int i = ENT - 1; i >= 0; i--)
      if (valid[i] && ((lk_vpn & ({VPN_W{1'b1}} << e_frag[i])) == e_vpn[i])) begin
        hit_c = 1'b1;
        sel   = IDX_W'(i);
      end
  end

  wire [VPN_W-1:0] low_bits = lk_vpn & ~({VPN_W{1'b1}} << e_frag[sel]);
  wire [PPN_W-1:0] ppn_c    = e_ppn[sel] | PPN_W'(low_bits);
  wire             take     = lk_req & ~flush & hit_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= '0;
      sp        <= '0;
      lp        <= '0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_flags <= '0;
    end else begin
      rsp_hit   <= take;
      rsp_pa    <= take ? {ppn_c, lk_va[11:0]} : '0;
      rsp_flags <= take ? e_flg[sel] : '0;
      if (flush) valid <= '0;
      else if (fill_ok) begin
        valid[widx] <= 1'b1;
        if (to_small) sp <= (sp == SP_W'(SMALL_N - 1)) ? '0 : sp + 1'b1;
        else          lp <= (lp == LP_W'(LARGE_N - 1)) ? '0 : lp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      e_vpn[widx]  <= fill_vpn & fill_mask;
      e_ppn[widx]  <= fill_pte[PPN_W+11:12] & PPN_W'({{(PPN_W > VPN_W ? PPN_W - VPN_W : 1){1'b1}}, fill_mask});
      e_flg[widx]  <= fill_pte[6:1];
      e_frag[widx] <= fill_frag;
    end
  end

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));
  assert_bad_fill_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_pte[0] && !flush) |=> $stable(valid));
  assert_small_fill_spares_large_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && to_small) |=> $stable(valid[ENT-1:SMALL_N]));
  assert_large_fill_spares_small_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !to_small) |=> $stable(valid[SMALL_N-1:0]));
  assert_hit_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $past(lk_req && !flush));
endmodule

// File: tb/test_frag_tlb.sv
module test_frag_tlb;
  localparam int VPN_W = 20, PPN_W = 28, SMALL_N = 4, LARGE_N = 16;
  localparam int ENT = SMALL_N + LARGE_N;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, lk_req = 1'b0, fill_en = 1'b0;
  logic [VPN_W+11:0] lk_va = '0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [PPN_W+11:0] fill_pte = '0;
  logic              rsp_hit;
  logic [PPN_W+11:0] rsp_pa;
  logic [5:0]        rsp_flags;

  frag_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SMALL_N(SMALL_N), .LARGE_N(LARGE_N)) i_frag_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_req(lk_req), .lk_va(lk_va),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_flags(rsp_flags));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural model
  bit          m_valid [ENT];
  longint      m_vpn [ENT], m_ppn [ENT];
  int          m_flg [ENT], m_frag [ENT];
  int          m_sp = 0, m_lp = 0;
  logic              exp_hit = 1'b0;
  logic [PPN_W+11:0] exp_pa = '0;
  logic [5:0]        exp_flags = '0;
  longint q_vpn, f_vpn, f_ppn, pg;
  int f, slot, found;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) m_valid[i] = 0;
      m_sp = 0; m_lp = 0;
      exp_hit <= 1'b0; exp_pa <= '0; exp_flags <= '0;
    end else begin
      q_vpn = longint'(lk_va >> 12);
      found = -1;
      for (int i = 0; i < ENT; i++)
        if (found < 0 && m_valid[i] && ((q_vpn >> m_frag[i]) == (m_vpn[i] >> m_frag[i])))
          found = i;
      if (lk_req && !flush && found >= 0) begin
        pg = m_ppn[found] + (q_vpn % (longint'(1) << m_frag[found]));
        exp_hit   <= 1'b1;
        exp_pa    <= PPN_W'(pg) * 4096 + (PPN_W+12)'(lk_va % 4096);
        exp_flags <= 6'(m_flg[found]);
      end else begin
        exp_hit <= 1'b0; exp_pa <= '0; exp_flags <= '0;
      end
      if (flush) begin
        for (int i = 0; i < ENT; i++) m_valid[i] = 0;
      end else if (fill_en && fill_pte[0]) begin
        f = int'(fill_pte[9:7]);
        if (f == 0) begin slot = m_sp; m_sp = (m_sp + 1) % SMALL_N; end
        else begin slot = SMALL_N + m_lp; m_lp = (m_lp + 1) % LARGE_N; end
        f_vpn = longint'(fill_vpn);
        f_ppn = longint'(fill_pte >> 12);
        m_valid[slot] = 1;
        m_vpn[slot]  = (f_vpn >> f) << f;
        m_ppn[slot]  = (f_ppn >> f) << f;
        m_flg[slot]  = int'(fill_pte[6:1]);
        m_frag[slot] = f;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      vectors++;
      if (rsp_hit !== exp_hit || rsp_pa !== exp_pa || rsp_flags !== exp_flags) begin
        fails++;
        $display("FAIL %s: hit/pa/flags got %0b/%h/%h expected %0b/%h/%h",
                 cur_req, rsp_hit, rsp_pa, rsp_flags, exp_hit, exp_pa, exp_flags);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got cycle %0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [PPN_W+11:0] mk_pte(int ppn, int frag, int flg, bit v);
    return {PPN_W'(ppn), 2'b00, 3'(frag), 6'(flg), v};
  endfunction

  task automatic step(bit fl, bit lr, longint vpn, int off, bit fe, longint fv, logic [PPN_W+11:0] pte);
    @(negedge clk);
    flush = fl; lk_req = lr; lk_va = {VPN_W'(vpn), 12'(off)};
    fill_en = fe; fill_vpn = VPN_W'(fv); fill_pte = pte;
  endtask
  task automatic look(longint vpn, int off); step(0, 1, vpn, off, 0, 0, '0); endtask
  task automatic fill(longint vpn, logic [PPN_W+11:0] pte); step(0, 0, 0, 0, 1, vpn, pte); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; look(0, 0); look('h123, 5); step(0, 0, 0, 0, 0, 0, '0);
    cur_req = "R2"; fill('h40, mk_pte('h777, 0, 3, 0)); look('h40, 0); step(0, 0, 0, 0, 0, 0, '0);
    cur_req = "R3"; fill('h125, mk_pte('hABC5, 4, 'h2A, 1));
    look('h120, 0); look('h12F, 'hFFF); look('h11F, 0); look('h130, 0);
    cur_req = "R4"; look('h127, 'h345); look('h12C, 1);
    cur_req = "R5"; step(0, 0, 'h120, 0, 0, 0, '0); step(0, 0, 0, 0, 0, 0, '0);
    cur_req = "R6";
    for (int i = 0; i < 5; i++) fill('h200 + i, mk_pte('h300 + i, 0, i, 1));
    for (int i = 0; i < 5; i++) look('h200 + i, 0);
    look('h120, 7);
    cur_req = "R7"; step(1, 1, 'h120, 0, 0, 0, '0); look('h120, 0);
    step(1, 0, 0, 0, 1, 'h500, mk_pte('h900, 2, 1, 1)); look('h500, 0);
    fill('h600, mk_pte('h910, 0, 9, 1)); look('h600, 0);
    cur_req = "R8"; step(0, 1, 'h700, 0, 1, 'h700, mk_pte('hC00, 3, 4, 1)); look('h703, 0);
    cur_req = "R9"; fill('h800, mk_pte('hD00, 5, 1, 1)); fill('h801, mk_pte('hE00, 0, 2, 1));
    look('h801, 0); look('h802, 0); fill('h810, mk_pte('hF00, 2, 3, 1)); look('h811, 0);
    cur_req = "R3/R4/R6/R7/R8/R9 random";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      step(r < 2, ($urandom % 4) != 0, 'h1000 + ($urandom % 64), int'($urandom % 4096),
           r >= 60, 'h1000 + ($urandom % 64),
           mk_pte(int'($urandom % 'h10000), (($urandom % 2) == 0) ? 0 : int'($urandom % 8),
                  int'($urandom % 64), ($urandom % 8) != 0));
    end
    step(0, 0, 0, 0, 0, 0, '0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule